// File: doc/BRIEF.md
# Four-Stage Escalating Watchdog

This block is a watchdog timer that escalates through four timeout stages in a fixed order. Each stage counts prescaled ticks up to its own limit. When the limit is reached, the stage performs its own action: nothing, an interrupt, a CPU reset pulse or a system reset pulse. The block then moves to the next stage, and after the last stage it wraps back to the first. Software keeps the watchdog quiet by writing the feed register before the stage with the first harmful action expires.

All configuration sits behind a write lock. A key register accepts any write. Writing the exact key value opens the configuration registers, and writing any other value closes them again. The feed register can always be written, so a locked watchdog can still be serviced. The two reset outputs produce pulses whose lengths are programmable. Clock generation and the downstream reset network are outside the block.

Top module: `wdt_top`

## Requirements
- R1: After reset, the block is locked and inactive. The irq_o, cpu_rst_o and sys_rst_o outputs are low. Every readable register reads 0 when the boot-arm default parameter is 0.
- R2: Word addresses are: 0 control, 1 divider, 2 to 5 the timeouts of stages 0 to 3, 6 feed, 7 key, 8 status. A write to address 7 unlocks the block only if the data equals the key parameter (default 32'hA5C30F17); any other value locks it. Address 7 reads the unlock state in bit 0. While the block is locked, writes to addresses 0 to 5 leave those registers unchanged.
- R3: A write to address 6 is accepted whether the block is locked or not. It returns the block to stage 0 with a cleared tick count and a cleared prescaler, and it clears the interrupt. The next expiry then follows a full stage-0 timeout.
- R4: One tick occurs every D clock cycles, where D is the value of the divider register. A divider value of 0 behaves as 1.
- R5: Stage s expires after T_s ticks counted from the start of the stage, where T_s is the stage's timeout and a value of 0 behaves as 1. On expiry the stage index advances by one, and stage 3 is followed by stage 0. With the block enabled at a clock edge, the first expiry occurs at the (T_0*D)-th following edge.
- R6: Control bits [16:9] hold the 2-bit actions of stages 0 to 3, with stage 0 in bits [10:9]. The codes are: 0 none, 1 interrupt, 2 CPU reset, 3 system reset. A stage with code 0 still advances but drives no output.
- R7: Control bit 2 selects edge mode. In level mode (bit 2 = 0), irq_o rises at the edge of an interrupt-coded expiry and stays high until a feed or a disable. In edge mode, irq_o is high for exactly one cycle per interrupt-coded expiry.
- R8: A CPU-reset expiry drives cpu_rst_o high for (control[5:3] + 1) cycles. A system-reset expiry drives sys_rst_o high for (control[8:6] + 1) cycles. Both pulses start at the edge of the expiry.
- R9: The watchdog is active when control bit 0 (enable) or control bit 1 (boot arm) is set. While it is inactive, it stays in stage 0, keeps its counts cleared and raises nothing.
- R10: Address 8 reads the current stage index in bits [1:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Register write strobe |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Watchdog interrupt |
| cpu_rst_o | output | 1 | CPU reset pulse |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
A wrong stage index or a corrupted tick count shows first on the status register. At the next expiry it also shows as an output firing on the wrong clock edge or with the wrong action, so the bench compares exact edge numbers rather than windows. A lock bit that is stuck open or stuck closed shows on the very next read of a configuration register. A faulty pulse counter shows within eight cycles as a wrong pulse width. A feed that fails to clear state shows at once on the status register and on irq_o, and then as an expiry at the wrong edge.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int unsigned NUM_STAGES  = 4;
  localparam int unsigned PULSE_LEN_W = 3;

  localparam int unsigned ADR_CTRL = 0;
  localparam int unsigned ADR_DIV  = 1;
  localparam int unsigned ADR_TMO0 = 2;
  localparam int unsigned ADR_FEED = 6;
  localparam int unsigned ADR_KEY  = 7;
  localparam int unsigned ADR_STAT = 8;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_IRQ  = 2'd1,
    ACT_CPU  = 2'd2,
    ACT_SYS  = 2'd3
  } wdt_act_e;

  typedef struct packed {
    logic [NUM_STAGES-1:0][1:0] act;
    logic [PULSE_LEN_W-1:0]     sys_len;
    logic [PULSE_LEN_W-1:0]     cpu_len;
    logic                       edge_irq;
    logic                       boot_arm;
    logic                       enable;
  } wdt_ctrl_t;

  localparam int unsigned CTRL_W = $bits(wdt_ctrl_t);
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned TMO_W    = 32,
  parameter logic [31:0] WKEY     = 32'hA5C3_0F17,
  parameter bit          BOOT_DEF = 1'b0
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [31:0]                         wdata_i,
  input  logic [1:0]                          stage_i,
  output logic [31:0]                         rdata_o,
  output wdt_ctrl_t                           ctrl_o,
  output logic [DIV_W-1:0]                    div_o,
  output logic [NUM_STAGES-1:0][TMO_W-1:0]    tmo_o,
  output logic                                unlocked_o,
  output logic                                feed_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADR_CTRL);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(ADR_DIV);
  localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(ADR_FEED);
  localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(ADR_KEY);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);

  wdt_ctrl_t                        ctrl_q;
  logic [DIV_W-1:0]                 div_q;
  logic [NUM_STAGES-1:0][TMO_W-1:0] tmo_q;
  logic                             unl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q          <= '0;
      ctrl_q.boot_arm <= BOOT_DEF;
      div_q           <= '0;
      tmo_q           <= '0;
      unl_q           <= 1'b0;
    end else if (we_i) begin
      if (addr_i == A_KEY) unl_q <= (wdata_i == WKEY);
      if (unl_q) begin
        if (addr_i == A_CTRL) ctrl_q <= wdt_ctrl_t'(wdata_i[CTRL_W-1:0]);
        if (addr_i == A_DIV)  div_q  <= wdata_i[DIV_W-1:0];
        for (int s = 0; s < NUM_STAGES; s++) begin
          if (addr_i == ADDR_W'(ADR_TMO0 + s)) tmo_q[s] <= wdata_i[TMO_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == A_CTRL) rdata_o[CTRL_W-1:0] = ctrl_q;
    if (addr_i == A_DIV)  rdata_o[DIV_W-1:0]  = div_q;
    for (int s = 0; s < NUM_STAGES; s++) begin
      if (addr_i == ADDR_W'(ADR_TMO0 + s)) rdata_o[TMO_W-1:0] = tmo_q[s];
    end
    if (addr_i == A_KEY)  rdata_o[0]   = unl_q;
    if (addr_i == A_STAT) rdata_o[1:0] = stage_i;
  end

  assign ctrl_o     = ctrl_q;
  assign div_o      = div_q;
  assign tmo_o      = tmo_q;
  assign unlocked_o = unl_q;
  assign feed_o     = we_i && (addr_i == A_FEED);
endmodule

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] div_m1;

  assign div_m1 = (div_i == '0) ? '0 : div_i - DIV_W'(1);
  // >= keeps ticking if the divider is lowered mid-count
  assign tick_o = active_i && (pre_q >= div_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     pre_q <= '0;
    else if (!active_i || restart_i) pre_q <= '0;
    else if (tick_o)                 pre_q <= '0;
    else                             pre_q <= pre_q + DIV_W'(1);
  end
endmodule

// File: rtl/wdt_stage_seq.sv
module wdt_stage_seq
  import wdt_pkg::*;
#(
  parameter int unsigned TMO_W = 32
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             active_i,
  input  logic                             restart_i,
  input  logic                             tick_i,
  input  logic [NUM_STAGES-1:0][TMO_W-1:0] tmo_i,
  output logic [1:0]                       stage_o,
  output logic                             expire_o
);
  logic [1:0]       stage_q;
  logic [TMO_W-1:0] cnt_q;
  logic             last;

  // zero timeout acts as one tick
  assign last     = ({1'b0, cnt_q} + (TMO_W+1)'(1)) >= {1'b0, tmo_i[stage_q]};
  assign expire_o = active_i && !restart_i && tick_i && last;
  assign stage_o  = stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else if (!active_i || restart_i) begin
      stage_q <= '0;
      cnt_q   <= '0;
    end else if (tick_i) begin
      if (last) begin
        stage_q <= stage_q + 2'd1;
        cnt_q   <= '0;
      end else begin
        cnt_q <= cnt_q + TMO_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
  parameter int unsigned LEN_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             pulse_o
);
  logic             busy_q;
  logic [LEN_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= len_i;
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - LEN_W'(1);
    end
  end

  assign pulse_o = busy_q;
endmodule

// File: rtl/wdt_top.sv
module wdt_top
  import wdt_pkg::*;
#(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned DIV_W    = 16,
  parameter int unsigned TMO_W    = 32,
  parameter logic [31:0] WKEY     = 32'hA5C3_0F17,
  parameter bit          BOOT_DEF = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  output logic              irq_o,
  output logic              cpu_rst_o,
  output logic              sys_rst_o
);
  localparam int unsigned NUM_RST = 2;

  wdt_ctrl_t                        ctrl;
  logic [DIV_W-1:0]                 div;
  logic [NUM_STAGES-1:0][TMO_W-1:0] tmo;
  logic                             unlocked;
  logic                             feed;
  logic [1:0]                       stage;
  logic                             active;
  logic                             tick;
  logic                             expire;
  wdt_act_e                         cur_act;
  logic                             irq_hit;
  logic                             irq_q;

  logic [NUM_RST-1:0]                  rst_start;
  logic [NUM_RST-1:0][PULSE_LEN_W-1:0] rst_len;
  logic [NUM_RST-1:0]                  rst_out;

  wdt_regs #(
    .ADDR_W(ADDR_W), .DIV_W(DIV_W), .TMO_W(TMO_W), .WKEY(WKEY), .BOOT_DEF(BOOT_DEF)
  ) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .stage_i   (stage),
    .rdata_o,
    .ctrl_o    (ctrl),
    .div_o     (div),
    .tmo_o     (tmo),
    .unlocked_o(unlocked),
    .feed_o    (feed)
  );

  assign active = ctrl.enable || ctrl.boot_arm;

  wdt_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk_i, .rst_ni,
    .active_i (active),
    .restart_i(feed),
    .div_i    (div),
    .tick_o   (tick)
  );

  wdt_stage_seq #(.TMO_W(TMO_W)) u_seq (
    .clk_i, .rst_ni,
    .active_i (active),
    .restart_i(feed),
    .tick_i   (tick),
    .tmo_i    (tmo),
    .stage_o  (stage),
    .expire_o (expire)
  );

  assign cur_act = wdt_act_e'(ctrl.act[stage]);
  assign irq_hit = expire && (cur_act == ACT_IRQ);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               irq_q <= 1'b0;
    else if (!active || feed)  irq_q <= 1'b0;
    else if (ctrl.edge_irq)    irq_q <= irq_hit;
    else if (irq_hit)          irq_q <= 1'b1;
  end
  assign irq_o = irq_q;

  assign rst_start[0] = expire && (cur_act == ACT_CPU);
  assign rst_start[1] = expire && (cur_act == ACT_SYS);
  assign rst_len[0]   = ctrl.cpu_len;
  assign rst_len[1]   = ctrl.sys_len;

  for (genvar g = 0; g < NUM_RST; g++) begin : g_rst
    wdt_pulse #(.LEN_W(PULSE_LEN_W)) u_pulse (
      .clk_i, .rst_ni,
      .start_i(rst_start[g]),
      .len_i  (rst_len[g]),
      .pulse_o(rst_out[g])
    );
  end

  assign cpu_rst_o = rst_out[0];
  assign sys_rst_o = rst_out[1];
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker
  import wdt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic              unlocked_i,
  input logic [CTRL_W-1:0] ctrl_i,
  input logic              feed_i,
  input logic              active_i,
  input logic              expire_i,
  input logic [1:0]        act_i,
  input logic [1:0]        stage_i,
  input logic              irq_i,
  input logic              cpu_rst_i,
  input logic              sys_rst_i
);
  AST_LOCKED_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !unlocked_i) |=> $stable(ctrl_i)); // R2

  AST_FEED_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    feed_i |=> (stage_i == 2'd0) && !irq_i); // R3

  AST_STAGE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(stage_i) |-> (stage_i == 2'($past(stage_i) + 2'd1)) || (stage_i == 2'd0)); // R5

  AST_CPU_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_rst_i) |-> $past(expire_i && act_i == ACT_CPU)); // R6

  AST_SYS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sys_rst_i) |-> $past(expire_i && act_i == ACT_SYS)); // R8

  AST_IRQ_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_i) |-> $past(expire_i)); // R7

  AST_IDLE_STAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (stage_i == 2'd0) && !irq_i); // R9
endmodule

bind wdt_top wdt_checker i_wdt_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .we_i      (we_i),
  .unlocked_i(unlocked),
  .ctrl_i    (ctrl),
  .feed_i    (feed),
  .active_i  (active),
  .expire_i  (expire),
  .act_i     (cur_act),
  .stage_i   (stage),
  .irq_i     (irq_o),
  .cpu_rst_i (cpu_rst_o),
  .sys_rst_i (sys_rst_o)
);

// File: tb/test_wdt_top.sv
module test_wdt_top;
  localparam logic [31:0] KEY = 32'hA5C3_0F17;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        we;
  logic [3:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq, cpu_rst, sys_rst;

  int n_chk = 0;
  int n_err = 0;
  int k_st[4];
  int irq_first, irq_cnt, cpu_first, cpu_cnt, sys_first, sys_cnt;

  always #4 clk = ~clk;

  wdt_top i_wdt_top (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .irq_o(irq), .cpu_rst_o(cpu_rst), .sys_rst_o(sys_rst)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  // sample n cycles after the last write edge, recording first occurrences
  task automatic mon(input int n);
    bit seen3 = 1'b0;
    logic [1:0] st;
    for (int s = 0; s < 4; s++) k_st[s] = -1;
    irq_first = -1; cpu_first = -1; sys_first = -1;
    irq_cnt = 0; cpu_cnt = 0; sys_cnt = 0;
    addr = 4'd8;
    for (int k = 1; k <= n; k++) begin
      @(negedge clk);
      #1;
      st = rdata[1:0];
      if (st == 2'd3) seen3 = 1'b1;
      for (int s = 1; s < 4; s++) if (st == 2'(s) && k_st[s] < 0) k_st[s] = k;
      if (st == 2'd0 && seen3 && k_st[0] < 0) k_st[0] = k;
      if (irq)     begin irq_cnt++; if (irq_first < 0) irq_first = k; end
      if (cpu_rst) begin cpu_cnt++; if (cpu_first < 0) cpu_first = k; end
      if (sys_rst) begin sys_cnt++; if (sys_first < 0) sys_first = k; end
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    rd(4'd0, d); chk("R1 ctrl", d, 0);
    rd(4'd1, d); chk("R1 div", d, 0);
    rd(4'd2, d); chk("R1 tmo0", d, 0);
    rd(4'd7, d); chk("R1 lock", d, 0);
    rd(4'd8, d); chk("R10 stage", d, 0);
    chk("R1 outputs", {irq, cpu_rst, sys_rst}, 0);
  endtask

  task automatic t_lock();
    logic [31:0] d;
    wr(4'd0, 32'h1);
    rd(4'd0, d); chk("R2 locked ctrl write", d, 0);
    wr(4'd7, 32'h1234);
    rd(4'd7, d); chk("R2 wrong key", d, 0);
    wr(4'd7, KEY);
    rd(4'd7, d); chk("R2 right key", d, 1);
  endtask

  // D=3, T={2,3,1,2}, actions irq/none/cpu/sys, cpu_len=2, sys_len=0
  task automatic t_seq();
    logic [31:0] d;
    wr(4'd1, 3); wr(4'd2, 2); wr(4'd3, 3); wr(4'd4, 1); wr(4'd5, 2);
    rd(4'd3, d); chk("R2 tmo1 readback", d, 3);
    wr(4'd0, 32'h1C211);
    mon(28);
    chk("R5 stage1 edge", k_st[1], 6);
    chk("R5 stage2 edge", k_st[2], 15);
    chk("R5 stage3 edge", k_st[3], 18);
    chk("R5 wrap to 0 edge", k_st[0], 24);
    chk("R6 irq first", irq_first, 6);
    chk("R7 level irq held", irq_cnt, 23);
    chk("R6 cpu first", cpu_first, 18);
    chk("R8 cpu width", cpu_cnt, 3);
    chk("R6 sys first", sys_first, 24);
    chk("R8 sys width", sys_cnt, 1);
  endtask

  task automatic t_feed();
    logic [31:0] d;
    wr(4'd7, 0);
    wr(4'd2, 50);
    rd(4'd2, d); chk("R2 relocked tmo0", d, 2);
    wr(4'd6, 1);
    rd(4'd8, d); chk("R3 feed stage", d, 0);
    chk("R3 feed irq", irq, 0);
    mon(6);
    chk("R3 restart timing", k_st[1], 6);
    chk("R3 irq after restart", irq_first, 6);
  endtask

  task automatic t_edge();
    logic [31:0] d;
    wr(4'd7, KEY);
    wr(4'd0, 0);
    @(negedge clk);
    rd(4'd8, d); chk("R9 disabled stage", d, 0);
    chk("R9 disabled irq", irq, 0);
    mon(12);
    chk("R9 no advance", k_st[1], -1);
    wr(4'd0, 32'h205);
    mon(7);
    chk("R7 edge irq count", irq_cnt, 1);
    chk("R7 edge irq edge", irq_first, 6);
  endtask

  task automatic t_boot();
    wr(4'd0, 0);
    wr(4'd0, 32'h2);
    mon(7);
    chk("R9 boot arm runs", k_st[1], 6);
    chk("R6 none action quiet", irq_cnt + cpu_cnt + sys_cnt, 0);
    wr(4'd0, 0);
  endtask

  task automatic t_div0();
    logic [31:0] d;
    wr(4'd1, 0); wr(4'd2, 4);
    rd(4'd1, d); chk("R4 div readback", d, 0);
    wr(4'd0, 32'h1);
    mon(5);
    chk("R4 div0 one clock per tick", k_st[1], 4);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog timeout");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; we = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_lock();
    t_seq();
    t_feed();
    t_edge();
    t_boot();
    t_div0();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule